// File: doc/BRIEF.md
# Split X/Y Dual-Read Data Memory

This block is a word-organised data memory addressed with 16-bit byte addresses. A fixed parameter splits the word range into a lower X region and an upper Y region. The memory has three access paths: a primary read port, a secondary read port and one write port. Outside dual-operand operations the primary port reads the whole memory as one linear space, and the secondary port stays idle. When `rd_dual` is set, the primary port fetches the X operand and the secondary port fetches the Y operand, both in the same cycle. Each operand then comes from its own bank over its own path.

Writes always decode against the combined space, whatever kind of read is in progress. Both read ports return registered data one cycle after the request. An address past the implemented depth reads as zero and is never written. If a dual-operand request points either operand at the wrong region, the block raises a per-operand error flag and returns zero for that operand.

Top module: `xy_data_mem`

## Requirements
- R1: While reset is asserted and after it is released with no request, `x_valid`, `y_valid`, `x_err`, `y_err` are low and both read data outputs are zero.
- R2: Read data and `x_valid` appear exactly one clock edge after `rd_en` is sampled high. A cycle with `rd_en` low gives `x_valid` low and `x_rdata` zero on the next cycle.
- R3: With `rd_dual` low, a word read returns the word at byte address `rd_addr` with bit 0 ignored. Words below `X_WORDS` come from the X bank and the words above come from the Y bank, all on `x_rdata`.
- R4: Byte accesses use bit 0 as the lane. Lane 0 is bits 7:0 and lane 1 is bits 15:8 of the word. A byte read returns the lane zero-extended. A byte write (`wr_data[7:0]`) changes only that lane.
- R5: With `rd_en` and `rd_dual` high, `x_rdata` and `y_rdata` both carry words on the next cycle, with `x_valid` and `y_valid` high together. `rd_byte` is ignored in this mode. `y_valid` is never high without a dual request.
- R6: In dual mode, an X operand address at or above the boundary (byte `2*X_WORDS`) sets `x_err` and returns zero on `x_rdata`.
- R7: In dual mode, a Y operand address below the boundary sets `y_err` and returns zero on `y_rdata`. A Y address beyond the implemented depth returns zero without an error.
- R8: Writes decode against the combined space in every mode, including cycles with a dual-operand read.
- R9: A read and a write to the same word in the same cycle return the old contents. The new contents are visible from the next read.
- R10: A read beyond the implemented depth (byte `2*(X_WORDS+Y_WORDS)` and up) returns zero. A write there changes no location; in particular, no lower address aliases it.
- R11: Reads with `rd_dual` low never raise `x_err` or `y_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request on the primary port |
| rd_dual | input | 1 | Request is a dual-operand fetch |
| rd_byte | input | 1 | Byte read (unified mode only) |
| rd_addr | input | ADDR_W | Primary / X operand byte address |
| y_addr | input | ADDR_W | Y operand byte address |
| wr_en | input | 1 | Write request |
| wr_byte | input | 1 | Byte write |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| x_rdata | output | DATA_W | Primary port read data |
| y_rdata | output | DATA_W | Y operand read data |
| x_valid | output | 1 | Primary read data valid |
| y_valid | output | 1 | Y operand read data valid |
| x_err | output | 1 | X operand region error |
| y_err | output | 1 | Y operand region error |

## Verification
The assertions check the per-cycle rules that can be stated from the ports alone. These are the one-cycle valid timing, and the fact that `y_valid` occurs only for dual requests. They also cover both region-error cases with their zero data, the silent zero for a far Y operand and for any unified read past the depth, the zero upper byte on byte reads, and the absence of errors on unified reads. Data contents can only be shown by the bench's scenarios against its own byte model. Those scenarios cover lane placement of byte writes and the old-data result of a same-word read and write. They also show that writes made during dual fetches and writes past the depth land where the combined map says, and nowhere else.

// File: rtl/xy_mem_pkg.sv
package xy_mem_pkg;

  // Which bank an address decodes to.
  typedef enum logic [1:0] {
    RGN_X    = 2'd0,
    RGN_Y    = 2'd1,
    RGN_NONE = 2'd2
  } region_e;

endpackage

// File: rtl/xy_addr_decode.sv
module xy_addr_decode
  import xy_mem_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int X_WORDS = 256,
  parameter int Y_WORDS = 256,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int XIW    = $clog2(X_WORDS),
  localparam int YIW    = $clog2(Y_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [XIW-1:0]    x_idx,
  output logic [YIW-1:0]    y_idx,
  output logic [LANE_W-1:0] lane
);

  logic [ADDR_W-1:0] word;
  logic [ADDR_W-1:0] y_off;

  always_comb begin
    word  = addr >> LANE_W;
    y_off = word - ADDR_W'(X_WORDS);
    lane  = LANE_W'(addr);
    x_idx = XIW'(word);
    y_idx = YIW'(y_off);
    if (32'(word) < 32'(X_WORDS)) begin
      region = RGN_X;
    end else if (32'(word) < 32'(X_WORDS + Y_WORDS)) begin
      region = RGN_Y;
    end else begin
      region = RGN_NONE;
    end
  end

endmodule

// File: rtl/xy_mem_bank.sv
module xy_mem_bank #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_d;

  // Storage array: no reset, per-lane write enables.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en && wr_be[l]) begin
        mem[wr_idx][l*8 +: 8] <= wr_data[l*8 +: 8];
      end
    end
  end

  // Read register: samples array contents before this edge's write.
  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = mem[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/xy_data_mem.sv
module xy_data_mem
  import xy_mem_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int X_WORDS = 256,
  parameter int Y_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_dual,
  input  logic              rd_byte,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] x_rdata,
  output logic [DATA_W-1:0] y_rdata,
  output logic              x_valid,
  output logic              y_valid,
  output logic              x_err,
  output logic              y_err
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int XIW    = $clog2(X_WORDS);
  localparam int YIW    = $clog2(Y_WORDS);

  // ---------------- address decode (three independent paths) ----------------
  region_e           xd_region, yd_region, wd_region;
  logic [XIW-1:0]    xd_xidx, yd_xidx, wd_xidx;
  logic [YIW-1:0]    xd_yidx, yd_yidx, wd_yidx;
  logic [LANE_W-1:0] xd_lane, yd_lane, wd_lane;

  xy_addr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .X_WORDS(X_WORDS), .Y_WORDS(Y_WORDS))
    u_dec_x (.addr(rd_addr), .region(xd_region), .x_idx(xd_xidx), .y_idx(xd_yidx), .lane(xd_lane));

  xy_addr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .X_WORDS(X_WORDS), .Y_WORDS(Y_WORDS))
    u_dec_y (.addr(y_addr), .region(yd_region), .x_idx(yd_xidx), .y_idx(yd_yidx), .lane(yd_lane));

  xy_addr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .X_WORDS(X_WORDS), .Y_WORDS(Y_WORDS))
    u_dec_w (.addr(wr_addr), .region(wd_region), .x_idx(wd_xidx), .y_idx(wd_yidx), .lane(wd_lane));

  // The Y operand is always a whole word in the Y bank; these decode outputs are not needed.
  logic unused_dec_bits;
  assign unused_dec_bits = ^{yd_xidx, yd_lane};

  // ---------------- bank request routing ----------------
  logic             xb_rd_en, yb_rd_en;
  logic [YIW-1:0]   yb_rd_idx;
  logic             xb_wr_en, yb_wr_en;
  logic [LANES-1:0] wr_be;
  logic [DATA_W-1:0] wr_word;

  always_comb begin
    xb_rd_en  = rd_en && (xd_region == RGN_X);
    if (rd_dual) begin
      yb_rd_en  = rd_en && (yd_region == RGN_Y);
      yb_rd_idx = yd_yidx;
    end else begin
      yb_rd_en  = rd_en && (xd_region == RGN_Y);
      yb_rd_idx = xd_yidx;
    end
  end

  // Writes always decode against the combined map.
  always_comb begin
    xb_wr_en = wr_en && (wd_region == RGN_X);
    yb_wr_en = wr_en && (wd_region == RGN_Y);
    if (wr_byte) begin
      wr_be   = LANES'(1) << wd_lane;
      wr_word = {LANES{wr_data[7:0]}};
    end else begin
      wr_be   = '1;
      wr_word = wr_data;
    end
  end

  logic [DATA_W-1:0] xb_data, yb_data;

  xy_mem_bank #(.DEPTH(X_WORDS), .DATA_W(DATA_W)) u_bank_x (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (xb_rd_en),
    .rd_idx  (xd_xidx),
    .rd_data (xb_data),
    .wr_en   (xb_wr_en),
    .wr_idx  (wd_xidx),
    .wr_be   (wr_be),
    .wr_data (wr_word)
  );

  xy_mem_bank #(.DEPTH(Y_WORDS), .DATA_W(DATA_W)) u_bank_y (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (yb_rd_en),
    .rd_idx  (yb_rd_idx),
    .rd_data (yb_data),
    .wr_en   (yb_wr_en),
    .wr_idx  (wd_yidx),
    .wr_be   (wr_be),
    .wr_data (wr_word)
  );

  // ---------------- response tracking (one stage, matches bank latency) ----------------
  typedef struct packed {
    region_e           xsrc;
    logic              ysel;
    logic              byte_rd;
    logic [LANE_W-1:0] lane;
    logic              xv;
    logic              yv;
    logic              xe;
    logic              ye;
  } rsp_t;

  rsp_t rsp_d, rsp_q;

  always_comb begin
    rsp_d.xv      = rd_en;
    rsp_d.yv      = rd_en && rd_dual;
    rsp_d.xe      = rd_en && rd_dual && (xd_region != RGN_X);
    rsp_d.ye      = rd_en && rd_dual && (yd_region == RGN_X);
    rsp_d.ysel    = rd_en && rd_dual && (yd_region == RGN_Y);
    rsp_d.byte_rd = rd_en && !rd_dual && rd_byte;
    rsp_d.lane    = xd_lane;
    if (!rd_en || (rd_dual && (xd_region != RGN_X))) begin
      rsp_d.xsrc = RGN_NONE;
    end else begin
      rsp_d.xsrc = xd_region;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= '{xsrc: RGN_NONE, default: '0};
    end else begin
      rsp_q <= rsp_d;
    end
  end

  // ---------------- output formatting ----------------
  logic [DATA_W-1:0] x_word;
  logic [7:0]        x_lane_byte;

  always_comb begin
    case (rsp_q.xsrc)
      RGN_X:   x_word = xb_data;
      RGN_Y:   x_word = yb_data;
      default: x_word = '0;
    endcase
    x_lane_byte = x_word[rsp_q.lane*8 +: 8];
    if (rsp_q.byte_rd) begin
      x_rdata = {{(DATA_W-8){1'b0}}, x_lane_byte};
    end else begin
      x_rdata = x_word;
    end
    y_rdata = rsp_q.ysel ? yb_data : '0;
  end

  assign x_valid = rsp_q.xv;
  assign y_valid = rsp_q.yv;
  assign x_err   = rsp_q.xe;
  assign y_err   = rsp_q.ye;

endmodule

// File: rtl/xy_data_mem_chk.sv
module xy_data_mem_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int X_WORDS = 256,
  parameter int Y_WORDS = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_dual,
  input logic              rd_byte,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] y_addr,
  input logic [DATA_W-1:0] x_rdata,
  input logic [DATA_W-1:0] y_rdata,
  input logic              x_valid,
  input logic              y_valid,
  input logic              x_err,
  input logic              y_err
);

  localparam int LANES     = DATA_W / 8;
  localparam int BOUND_B   = X_WORDS * LANES;
  localparam int TOTAL_B   = (X_WORDS + Y_WORDS) * LANES;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> x_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!x_valid && x_rdata == '0));

  assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_dual) |=> (x_valid && y_valid));

  assert_ysolo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_dual) |=> (!y_valid && y_rdata == '0));

  assert_xregion_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_dual && 32'(rd_addr) >= 32'(BOUND_B)) |=> (x_err && x_rdata == '0));

  assert_yregion_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_dual && 32'(y_addr) < 32'(BOUND_B)) |=> (y_err && y_rdata == '0));

  assert_yfar_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_dual && 32'(y_addr) >= 32'(TOTAL_B)) |=> (!y_err && y_rdata == '0));

  assert_bytezx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_dual && rd_byte) |=> (x_rdata[DATA_W-1:8] == '0));

  assert_farzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_dual && 32'(rd_addr) >= 32'(TOTAL_B)) |=> (x_rdata == '0));

  assert_noerr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_dual) |=> (!x_err && !y_err));

endmodule

bind xy_data_mem xy_data_mem_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .X_WORDS(X_WORDS), .Y_WORDS(Y_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_dual(rd_dual), .rd_byte(rd_byte),
  .rd_addr(rd_addr), .y_addr(y_addr), .x_rdata(x_rdata), .y_rdata(y_rdata),
  .x_valid(x_valid), .y_valid(y_valid), .x_err(x_err), .y_err(y_err)
);

// File: tb/xy_data_mem_test.sv
`timescale 1ns/1ps
module xy_data_mem_test;

  localparam int XW      = 256;
  localparam int YW      = 256;
  localparam int BOUND_B = XW * 2;
  localparam int TOTAL_B = (XW + YW) * 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, rd_dual, rd_byte, wr_en, wr_byte;
  logic [15:0] rd_addr, y_addr, wr_addr, wr_data;
  logic [15:0] x_rdata, y_rdata;
  logic        x_valid, y_valid, x_err, y_err;

  always #4 clk = ~clk;

  xy_data_mem #(.ADDR_W(16), .DATA_W(16), .X_WORDS(XW), .Y_WORDS(YW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_dual(rd_dual), .rd_byte(rd_byte),
    .rd_addr(rd_addr), .y_addr(y_addr), .wr_en(wr_en), .wr_byte(wr_byte),
    .wr_addr(wr_addr), .wr_data(wr_data), .x_rdata(x_rdata), .y_rdata(y_rdata),
    .x_valid(x_valid), .y_valid(y_valid), .x_err(x_err), .y_err(y_err)
  );

  typedef struct {
    logic        xv;
    logic [15:0] xd;
    logic        yv;
    logic [15:0] yd;
    logic        xe;
    logic        ye;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  model [TOTAL_B];
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  function automatic logic [15:0] mword(input int a);
    int e;
    e = a & ~1;
    return {model[e + 1], model[e]};
  endfunction

  // Driver: apply one cycle of stimulus and push what should appear one edge later.
  task automatic op(input bit rd, input bit dual, input bit rb, input int xa, input int ya,
                    input bit wr, input bit wb, input int wa, input logic [15:0] wd,
                    input string tag);
    exp_t e;
    @(negedge clk);
    rd_en = rd; rd_dual = dual; rd_byte = rb; rd_addr = 16'(xa); y_addr = 16'(ya);
    wr_en = wr; wr_byte = wb; wr_addr = 16'(wa); wr_data = wd;
    e.tag = tag;
    e.xv = rd; e.xd = '0; e.xe = 1'b0;
    e.yv = rd && dual; e.yd = '0; e.ye = 1'b0;
    if (rd && !dual) begin
      if (xa < TOTAL_B) e.xd = rb ? {8'h00, model[xa]} : mword(xa);
    end else if (rd && dual) begin
      if (xa >= BOUND_B) e.xe = 1'b1;
      else e.xd = mword(xa);
      if (ya < BOUND_B) e.ye = 1'b1;
      else if (ya < TOTAL_B) e.yd = mword(ya);
    end
    sb.push_back(e);
    if (wr && wa < TOTAL_B) begin
      if (wb) model[wa] = wd[7:0];
      else begin
        model[wa & ~1]       = wd[7:0];
        model[(wa & ~1) + 1] = wd[15:8];
      end
    end
  endtask

  task automatic rd_u(input int a, input bit rb, input string tag);
    op(1, 0, rb, a, 0, 0, 0, 0, 16'h0, tag);
  endtask

  task automatic rd_d(input int xa, input int ya, input bit rb, input string tag);
    op(1, 1, rb, xa, ya, 0, 0, 0, 16'h0, tag);
  endtask

  task automatic wr_w(input int a, input bit wb, input logic [15:0] d, input string tag);
    op(0, 0, 0, 0, 0, 1, wb, a, d, tag);
  endtask

  // Monitor: compare the design's outputs against the oldest expected item.
  always begin
    exp_t e;
    @(posedge clk);
    #2;
    if (rst_n && sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (x_valid !== e.xv || x_rdata !== e.xd || y_valid !== e.yv ||
          y_rdata !== e.yd || x_err !== e.xe || y_err !== e.ye) begin
        errors++;
        $display("FAIL %s: act xv=%b xd=%h yv=%b yd=%h xe=%b ye=%b exp xv=%b xd=%h yv=%b yd=%h xe=%b ye=%b",
                 e.tag, x_valid, x_rdata, y_valid, y_rdata, x_err, y_err,
                 e.xv, e.xd, e.yv, e.yd, e.xe, e.ye);
      end
    end
  end

  task automatic check_quiet(input string tag);
    checks++;
    if (x_valid !== 1'b0 || y_valid !== 1'b0 || x_err !== 1'b0 || y_err !== 1'b0 ||
        x_rdata !== 16'h0 || y_rdata !== 16'h0) begin
      errors++;
      $display("FAIL %s: act xv=%b yv=%b xe=%b ye=%b xd=%h yd=%h exp all zero",
               tag, x_valid, y_valid, x_err, y_err, x_rdata, y_rdata);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act run still busy exp finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TOTAL_B; i++) model[i] = 8'h00;
    rst_n = 1'b0;
    rd_en = 0; rd_dual = 0; rd_byte = 0; rd_addr = 0; y_addr = 0;
    wr_en = 0; wr_byte = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_quiet("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_quiet("R1 after release");

    // Fill the whole combined space through the write port (R8).
    for (int i = 0; i < XW + YW; i++) begin
      wr_w(i * 2, 0, 16'(i * 16'h0101) ^ 16'h5A3C, "R8 fill");
    end

    // R3: unified word reads over both regions; LSB ignored.
    rd_u(16'h0010, 0, "R3 X word");
    rd_u(16'h0011, 0, "R3 odd LSB ignored");
    rd_u(16'h01FE, 0, "R3 last X word");
    rd_u(16'h0200, 0, "R3 first Y word");
    rd_u(16'h03FE, 0, "R3 last Y word");
    rd_u(16'h0000, 0, "R2 back-to-back");
    op(0, 0, 0, 0, 0, 0, 0, 0, 16'h0, "R2 idle");

    // R4: byte reads and byte writes.
    rd_u(16'h0020, 1, "R4 byte lane0");
    rd_u(16'h0021, 1, "R4 byte lane1");
    rd_u(16'h0301, 1, "R4 byte lane1 in Y");
    wr_w(16'h0041, 1, 16'h77EE, "R4 byte write lane1");
    rd_u(16'h0040, 0, "R4 word after lane1 write");
    wr_w(16'h0250, 1, 16'h99C3, "R4 byte write lane0 Y");
    rd_u(16'h0250, 0, "R4 word after lane0 write");

    // R5: dual fetch, rd_byte ignored.
    rd_d(16'h0100, 16'h0280, 0, "R5 dual fetch");
    rd_d(16'h0002, 16'h03FE, 1, "R5 dual byte flag ignored");
    rd_d(16'h01FE, 16'h0200, 0, "R5 dual at boundary edges");

    // R6 / R7: region errors.
    rd_d(16'h0200, 16'h0300, 0, "R6 X operand in Y");
    rd_d(16'h0500, 16'h0300, 0, "R6 X operand past depth");
    rd_d(16'h0010, 16'h0010, 0, "R7 Y operand in X");
    rd_d(16'h0010, 16'h0500, 0, "R7 Y operand past depth");
    rd_d(16'h0300, 16'h0100, 0, "R6 R7 both wrong");

    // R8: writes during dual fetches use the combined map.
    op(1, 1, 0, 16'h0030, 16'h0290, 1, 0, 16'h0290, 16'hBEEF, "R8 R9 dual with Y write");
    rd_u(16'h0290, 0, "R8 unified sees Y write");
    op(1, 1, 0, 16'h0030, 16'h0290, 1, 0, 16'h0032, 16'h1234, "R8 dual with X write");
    rd_u(16'h0032, 0, "R8 unified sees X write");

    // R9: same-word read and write in one cycle returns old data.
    op(1, 0, 0, 16'h0060, 0, 1, 0, 16'h0060, 16'hCAFE, "R9 read during write");
    rd_u(16'h0060, 0, "R9 next read new");

    // R10: past the depth.
    rd_u(16'h0500, 0, "R10 far read zero");
    rd_u(16'hFFFF, 1, "R10 far byte read zero");
    wr_w(TOTAL_B + 4, 0, 16'hDEAD, "R10 far write");
    rd_u(16'h0004, 0, "R10 no alias at low word");
    wr_w(16'hFFFE, 0, 16'hF00D, "R10 top write");
    rd_u(16'h01FE, 0, "R10 last X word untouched");
    rd_u(16'h03FE, 0, "R10 R11 last Y word untouched");

    op(0, 0, 0, 0, 0, 0, 0, 0, 16'h0, "R2 drain");
    op(0, 0, 0, 0, 0, 0, 0, 0, 16'h0, "R2 drain");
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule